// File: doc/BRIEF.md
# Selectable Reversible 3x3 Gate Unit

This block is a purely combinational three-line reversible gate whose function is chosen by a select code. Three data bits enter as A, B and C and leave as P, Q and R. The select code picks one of five reversible mappings: single-line inversion, controlled inversion, doubly controlled inversion, controlled swap, or the combined controlled-inversion gate that adds a doubly controlled stage. Every mapping is a one-to-one function on the eight 3-bit vectors, so the input can always be recovered from the output.

A direction bit chooses forward or inverse operation. Four of the mappings undo themselves, so in inverse mode they apply the same function again. The combined gate does not undo itself, so it has a separate inverse path. Applying a mapping forward and then feeding its output back in inverse mode returns the original vector. Select codes with no gate assigned leave all three lines unchanged. The unit holds no state, has no clock and has no feedback path. No stage output drives more than one gate input within that stage.

Top module: `rev3_gate_unit`

## Requirements
- R1: With select code 0 (inversion), P = NOT A, Q = B and R = C.
- R2: With select code 1 (controlled inversion), P = A, Q = A XOR B and R = C.
- R3: With select code 2 (doubly controlled inversion), P = A, Q = B and R = (A AND B) XOR C. With C held at 0, R is A AND B. With C held at 1, R is A NAND B.
- R4: With select code 3 (controlled swap), P = A. When A is 0, Q = B and R = C. When A is 1, Q = C and R = B. The number of ones on the outputs equals the number of ones on the inputs.
- R5: With select code 4 (combined gate) and inverse = 0, P = A, Q = A XOR B and R = (A AND B) XOR C.
- R6: For select codes 0 to 3, inverse = 1 gives exactly the same outputs as inverse = 0.
- R7: With select code 4 and inverse = 1, P = A, Q = A XOR B and R = C XOR (A AND (A XOR B)).
- R8: Select codes 5, 6 and 7 give P = A, Q = B and R = C in both directions.
- R9: For every select code and both values of inverse, the eight input vectors give eight distinct output vectors.
- R10: For every select code, the forward output fed back with inverse = 1 reproduces the original {A,B,C}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_a | input | 1 | Data line A. It is the control line for every gate except inversion. |
| in_b | input | 1 | Data line B |
| in_c | input | 1 | Data line C |
| gate_sel | input | 3 | Gate select code: 0 inversion, 1 controlled inversion, 2 doubly controlled inversion, 3 controlled swap, 4 combined gate, 5 to 7 pass-through |
| inverse | input | 1 | 0 applies the forward mapping, 1 applies its inverse |
| out_p | output | 1 | Output line P |
| out_q | output | 1 | Output line Q |
| out_r | output | 1 | Output line R |

## Verification
The embedded assertions assume that the data lines, the select code and the direction bit are all known values. They skip any evaluation while one of these is unknown, because the bijection and round-trip properties have no meaning on undefined bits. The stimulus sets every input before its first comparison and never drives X or Z. It also walks the undefined select codes on purpose, so the round-trip assertion runs on the pass-through path as well as on the five gates.

// File: rtl/rg_pkg.sv
// Package: shared constants, select codes and an assertion-only reference
// mapping for the selectable reversible gate unit.
// Assumes: vectors are packed {A,B,C} with A in the most significant bit.
package rg_pkg;

    localparam int RG_VEC_W     = 3;
    localparam int RG_SEL_W     = 3;
    localparam int RG_NUM_KINDS = 5;

    // Bit positions of the three lines inside a packed vector
    localparam int RG_IA = 2;
    localparam int RG_IB = 1;
    localparam int RG_IC = 0;

    typedef enum logic [RG_SEL_W-1:0] {
        GK_INV   = 3'd0,
        GK_CINV  = 3'd1,
        GK_CCINV = 3'd2,
        GK_CSWAP = 3'd3,
        GK_COMBO = 3'd4
    } gate_kind_e;

    // Reference mapping, written apart from the cells and used only by checks.
    function automatic logic [RG_VEC_W-1:0] rg_model(
        input logic [RG_SEL_W-1:0] kind,
        input logic                inv,
        input logic [RG_VEC_W-1:0] v
    );
        logic x, y, z;
        {x, y, z} = v;
        case (kind)
            3'd0:    rg_model = {~x, y, z};
            3'd1:    rg_model = {x, x ^ y, z};
            3'd2:    rg_model = {x, y, z ^ (x & y)};
            3'd3:    rg_model = x ? {x, z, y} : {x, y, z};
            3'd4:    rg_model = inv ? {x, x ^ y, z ^ (x & (x ^ y))}
                                    : {x, x ^ y, z ^ (x & y)};
            default: rg_model = v;
        endcase
    endfunction

endpackage

// File: rtl/rg_cell.sv
// Module: one reversible 3x3 gate stage, variant picked by parameter KIND.
// Assumes: KIND is one of the gate_kind_e codes. Only the combined gate
// uses the direction input; the other variants are their own inverse.
module rg_cell import rg_pkg::*; #(
    parameter int KIND = 0
) (
    input  logic [RG_VEC_W-1:0] vec_i,
    input  logic                inv_i,
    output logic [RG_VEC_W-1:0] vec_o
);

    generate
        if (KIND == int'(GK_INV)) begin : g_inv
            logic unused_dir;
            assign unused_dir = inv_i;
            // Invert line A, pass B and C
            always_comb begin
                vec_o        = vec_i;
                vec_o[RG_IA] = ~vec_i[RG_IA];
            end
            // Guard: the passive lines are untouched
            always_comb begin
                if (!$isunknown(vec_i)) begin
                    assert_inv_passive_R1: assert (vec_o[RG_IB:RG_IC] == vec_i[RG_IB:RG_IC])
                        else $error("inversion stage altered B or C");
                end
            end
        end else if (KIND == int'(GK_CINV)) begin : g_cinv
            logic unused_dir;
            assign unused_dir = inv_i;
            // Flip B when A is set
            always_comb begin
                vec_o        = vec_i;
                vec_o[RG_IB] = vec_i[RG_IB] ^ vec_i[RG_IA];
            end
            // Guard: lines A and C are unchanged
            always_comb begin
                if (!$isunknown(vec_i)) begin
                    assert_cinv_ac_kept_R2: assert (vec_o[RG_IA] == vec_i[RG_IA] && vec_o[RG_IC] == vec_i[RG_IC])
                        else $error("controlled inversion altered A or C");
                end
            end
        end else if (KIND == int'(GK_CCINV)) begin : g_ccinv
            logic unused_dir;
            assign unused_dir = inv_i;
            // Flip C when both A and B are set
            always_comb begin
                vec_o        = vec_i;
                vec_o[RG_IC] = vec_i[RG_IC] ^ (vec_i[RG_IA] & vec_i[RG_IB]);
            end
            // Guard: both control lines are unchanged
            always_comb begin
                if (!$isunknown(vec_i)) begin
                    assert_ccinv_ctrl_R3: assert (vec_o[RG_IA:RG_IB] == vec_i[RG_IA:RG_IB])
                        else $error("doubly controlled inversion altered a control line");
                end
            end
        end else if (KIND == int'(GK_CSWAP)) begin : g_cswap
            logic unused_dir;
            assign unused_dir = inv_i;
            // Exchange B and C when A is set
            always_comb begin
                vec_o = vec_i;
                if (vec_i[RG_IA]) begin
                    vec_o[RG_IB] = vec_i[RG_IC];
                    vec_o[RG_IC] = vec_i[RG_IB];
                end
            end
            // Guard: a swap keeps the number of ones
            always_comb begin
                if (!$isunknown(vec_i)) begin
                    assert_cswap_weight_R4: assert ($countones(vec_o) == $countones(vec_i))
                        else $error("controlled swap changed the number of ones");
                end
            end
        end else begin : g_combo
            logic b_orig;
            // Combined gate, with the original B recovered first in inverse mode
            always_comb begin
                b_orig       = inv_i ? (vec_i[RG_IA] ^ vec_i[RG_IB]) : vec_i[RG_IB];
                vec_o[RG_IA] = vec_i[RG_IA];
                vec_o[RG_IB] = vec_i[RG_IA] ^ vec_i[RG_IB];
                vec_o[RG_IC] = vec_i[RG_IC] ^ (vec_i[RG_IA] & b_orig);
            end
            // Guard: with A clear the gate leaves every line alone
            always_comb begin
                if (!$isunknown({vec_i, inv_i}) && !vec_i[RG_IA]) begin
                    assert_combo_idle_R7: assert (vec_o == vec_i)
                        else $error("combined gate changed lines while A is clear");
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rg_select.sv
// Module: picks one candidate gate output by select code. Codes with no
// gate assigned return the unchanged input vector.
// Assumes: candidate k corresponds to select code k.
module rg_select #(
    parameter int N  = 5,
    parameter int W  = 3,
    parameter int SW = 3
) (
    input  logic [SW-1:0]       sel_i,
    input  logic [W-1:0]        pass_i,
    input  logic [N-1:0][W-1:0] cand_i,
    output logic [W-1:0]        vec_o
);

    // Priority-free selection: at most one code matches
    always_comb begin
        vec_o = pass_i;
        for (int k = 0; k < N; k++) begin
            if (sel_i == SW'(k)) vec_o = cand_i[k];
        end
    end

    // Guard: unassigned codes pass the vector through
    always_comb begin
        if (!$isunknown({sel_i, pass_i}) && (int'(sel_i) >= N)) begin
            assert_unused_code_pass_R8: assert (vec_o == pass_i)
                else $error("unassigned select code altered the vector");
        end
    end

endmodule

// File: rtl/rev3_gate_unit.sv
// Module: selectable reversible 3x3 gate unit (top). One stage per gate
// kind is built in parallel and the select code picks one result.
// Assumes: purely combinational; gate_sel and inverse are static for the
// duration of any use of the outputs.
module rev3_gate_unit import rg_pkg::*; (
    input  logic                in_a,
    input  logic                in_b,
    input  logic                in_c,
    input  logic [RG_SEL_W-1:0] gate_sel,
    input  logic                inverse,
    output logic                out_p,
    output logic                out_q,
    output logic                out_r
);

    localparam int NK = RG_NUM_KINDS;

    logic [RG_VEC_W-1:0]        vin;
    logic [RG_VEC_W-1:0]        vout;
    logic [NK-1:0][RG_VEC_W-1:0] cand;

    assign vin = {in_a, in_b, in_c};

    generate
        for (genvar k = 0; k < NK; k++) begin : g_stage
            rg_cell #(.KIND(k)) u_cell (
                .vec_i (vin),
                .inv_i (inverse),
                .vec_o (cand[k])
            );
        end
    endgenerate

    rg_select #(.N(NK), .W(RG_VEC_W), .SW(RG_SEL_W)) u_pick (
        .sel_i  (gate_sel),
        .pass_i (vin),
        .cand_i (cand),
        .vec_o  (vout)
    );

    assign {out_p, out_q, out_r} = vout;

    // Guard: the opposite direction undoes what was applied
    always_comb begin
        if (!$isunknown({vin, gate_sel, inverse})) begin
            assert_roundtrip_R10: assert (rg_model(gate_sel, ~inverse, vout) == vin)
                else $error("output does not map back to the input");
            if (gate_sel >= 3'd1 && gate_sel <= 3'd4) begin
                assert_ctrl_line_kept_R5: assert (out_p == in_a)
                    else $error("control line A not preserved on P");
            end
        end
    end

endmodule

// File: tb/rev3_gate_unit_bench.sv
module rev3_gate_unit_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       a, b, c, dir;
    logic [2:0] sel;
    logic       p, q, r;
    int         total = 0;
    int         bad = 0;
    int         cycles = 0;

    rev3_gate_unit u_rev3_gate_unit (
        .in_a(a), .in_b(b), .in_c(c), .gate_sel(sel), .inverse(dir),
        .out_p(p), .out_q(q), .out_r(r)
    );

    // Forward expectations: {select code, input ABC, expected PQR}
    localparam logic [8:0] FWD [40] = '{
        9'b000_000_100, 9'b000_001_101, 9'b000_010_110, 9'b000_011_111,
        9'b000_100_000, 9'b000_101_001, 9'b000_110_010, 9'b000_111_011,
        9'b001_000_000, 9'b001_001_001, 9'b001_010_010, 9'b001_011_011,
        9'b001_100_110, 9'b001_101_111, 9'b001_110_100, 9'b001_111_101,
        9'b010_000_000, 9'b010_001_001, 9'b010_010_010, 9'b010_011_011,
        9'b010_100_100, 9'b010_101_101, 9'b010_110_111, 9'b010_111_110,
        9'b011_000_000, 9'b011_001_001, 9'b011_010_010, 9'b011_011_011,
        9'b011_100_100, 9'b011_101_110, 9'b011_110_101, 9'b011_111_111,
        9'b100_000_000, 9'b100_001_001, 9'b100_010_010, 9'b100_011_011,
        9'b100_100_110, 9'b100_101_111, 9'b100_110_101, 9'b100_111_100
    };

    task automatic apply(input logic [2:0] s, input logic d, input logic [2:0] v,
                         output logic [2:0] o);
        @(negedge clk);
        sel = s; dir = d; {a, b, c} = v;
        #1;
        o = {p, q, r};
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] o, o2, x;
        logic [7:0] seen;
        string      tag;
        sel = 3'd0; dir = 1'b0; {a, b, c} = 3'b000;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Start-up state: all-zero inputs under inversion give P only (R1)
        apply(3'd0, 1'b0, 3'b000, o);
        chk("R1 startup", {5'd0, o}, 8'b100);

        // Table walk, forward and (for self-inverse kinds) inverse
        foreach (FWD[i]) begin
            tag = (FWD[i][8:6] == 3'd0) ? "R1" : (FWD[i][8:6] == 3'd1) ? "R2" :
                  (FWD[i][8:6] == 3'd2) ? "R3" : (FWD[i][8:6] == 3'd3) ? "R4" : "R5";
            apply(FWD[i][8:6], 1'b0, FWD[i][5:3], o);
            chk(tag, {5'd0, o}, {5'd0, FWD[i][2:0]});
            if (FWD[i][8:6] != 3'd4) begin
                apply(FWD[i][8:6], 1'b1, FWD[i][5:3], o);
                chk("R6 self-inverse", {5'd0, o}, {5'd0, FWD[i][2:0]});
            end
        end

        // Doubly controlled inversion as AND and NAND (R3)
        for (int v = 0; v < 4; v++) begin
            apply(3'd2, 1'b0, {v[1:0], 1'b0}, o);
            chk("R3 and", {7'd0, o[0]}, {7'd0, v[1] & v[0]});
            apply(3'd2, 1'b0, {v[1:0], 1'b1}, o);
            chk("R3 nand", {7'd0, o[0]}, {7'd0, ~(v[1] & v[0])});
        end

        // Combined gate inverse (R7)
        for (int v = 0; v < 8; v++) begin
            x = 3'(v);
            apply(3'd4, 1'b1, x, o);
            chk("R7", {5'd0, o},
                {5'd0, x[2], x[2] ^ x[1], x[0] ^ (x[2] & (x[2] ^ x[1]))});
        end

        // Unassigned codes pass through in both directions (R8)
        for (int s = 5; s < 8; s++) begin
            for (int d = 0; d < 2; d++) begin
                for (int v = 0; v < 8; v++) begin
                    apply(3'(s), d[0], 3'(v), o);
                    chk("R8", {5'd0, o}, {5'd0, 3'(v)});
                end
            end
        end

        // Distinct outputs per code and direction (R9)
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 2; d++) begin
                seen = 8'd0;
                for (int v = 0; v < 8; v++) begin
                    apply(3'(s), d[0], 3'(v), o);
                    seen[o] = 1'b1;
                end
                chk("R9 bijection", seen, 8'hFF);
            end
        end

        // Forward then inverse recovers the input (R10)
        for (int s = 0; s < 8; s++) begin
            for (int v = 0; v < 8; v++) begin
                apply(3'(s), 1'b0, 3'(v), o);
                apply(3'(s), 1'b1, o, o2);
                chk("R10 roundtrip", {5'd0, o2}, {5'd0, 3'(v)});
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule